// File: doc/BRIEF.md
# Bridge Interrupt Status Register with Mailbox Flags

This block holds one 32-bit interrupt status word for a bus bridge. A local register port reads and writes it at a single fixed byte offset. The word gathers three kinds of event source:

- a sticky flag that records a low-to-high transition on the legacy interrupt line;
- six live copies of error flags taken from the PCI configuration status word;
- one sticky flag per mailbox, raised whenever the PCI side writes that mailbox.

Software clears a sticky flag by writing 1 to it. A new event in the same cycle as a clear always wins, so no event is lost. The mirrored error bits cannot be changed through this register. They drop only when their source bits in the configuration status word drop.

A registered combined interrupt output is high while any sticky flag or any mirrored error bit is set. Reads return data one cycle after the read strobe. The edge flag exists only when the bridge is built for host-bridge operation.

Top module: `irq_status_reg`

## Requirements
- R1: After synchronous reset, every sticky flag and the stored previous line value are 0, `rdata` is 0 and `irq_out` is 0.
- R2: Bit 7 becomes 1 on the clock edge where `line_in` is 1 and its registered previous value is 0. A steady level or a falling transition does not set it.
- R3: Writing 1 to bit 7 clears it, unless a rising transition of `line_in` is detected on the same edge. In that case bit 7 stays 1.
- R4: With `HOST_MODE` = 0, bit 7 always reads 0 and never drives `irq_out`.
- R5: Bits 13:8 read the live values of `cfg_status` bits 15, 14, 13, 12, 11 and 8. Bit 13 takes `cfg_status[15]` and bit 8 takes `cfg_status[8]`. The mapping is: 13←15, 12←14, 11←13, 10←12, 9←11, 8←8.
- R6: Writes of any value to bits 13:8 have no effect on what those bits read.
- R7: Bit 16+n (n = 0..7) becomes 1 on the edge where `mbox_wr[n]` is 1. Writing 1 to that bit clears it, unless `mbox_wr[n]` is 1 on the same edge, in which case it stays 1.
- R8: Writing 0 to a sticky bit leaves it unchanged.
- R9: Bits 6:0, 15:14 and 31:24 always read 0.
- R10: The register responds only at byte offset 0x3060. With `rd_en` high at that offset, `rdata` shows the word on the following cycle. At any other offset, or with `rd_en` low, `rdata` is 0 on the following cycle. A write at any other offset changes nothing.
- R11: `irq_out` is registered and equals the OR of all sticky flags and mirrored bits. It changes on the same edge as the flags it reflects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Local write strobe |
| rd_en | input | 1 | Local read strobe |
| addr | input | 16 | Local byte address |
| wdata | input | 32 | Write data (1 clears a sticky bit) |
| rdata | output | 32 | Registered read data |
| line_in | input | 1 | Legacy interrupt line being watched |
| cfg_status | input | 16 | PCI configuration status word |
| mbox_wr | input | 8 | One pulse per mailbox write from the PCI side |
| irq_out | output | 1 | Registered combined interrupt |

## Verification
The assertions assume that `line_in`, `cfg_status` and `mbox_wr` are synchronous to `clk` and stable around each rising edge. They also assume the mirrored inputs may change freely between reads. The bench drives every input on the falling edge and samples outputs on the next falling edge, so each stimulus is seen by exactly one rising edge. The mirror sweep steps through all 64 combinations of the mapped status bits while filling the unmapped ones with varying data. The mailbox sweep raises, collides and clears every flag in turn.

// File: rtl/isr_pkg.sv
package isr_pkg;
  localparam int STAT_W   = 32;
  localparam int CFG_W    = 16;
  localparam int EDGE_BIT = 7;
  localparam int MIR_LSB  = 8;
  localparam int MIR_N    = 6;
  localparam int MBOX_LSB = 16;
  localparam int MBOX_MAX = 8;

  // Source bit in the configuration status word for mirror slot k
  function automatic int mir_src(input int k);
    case (k)
      0:       return 8;
      1:       return 11;
      2:       return 12;
      3:       return 13;
      4:       return 14;
      default: return 15;
    endcase
  endfunction
endpackage

// File: rtl/isr_edge_flag.sv
module isr_edge_flag (
  input  logic clk,
  input  logic rst,
  input  logic line,
  input  logic clr,
  output logic flag_q,
  output logic flag_nxt
);
  logic prev_q;
  logic rise;

  assign rise     = line & ~prev_q;
  assign flag_nxt = rise | (flag_q & ~clr);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      prev_q <= line;
      flag_q <= flag_nxt;
    end
  end
endmodule

// File: rtl/isr_sticky_bank.sv
module isr_sticky_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q,
  output logic [N-1:0] nxt
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    assign nxt[i] = set[i] | (q[i] & ~clr[i]);
    always_ff @(posedge clk) begin
      if (rst) q[i] <= 1'b0;
      else     q[i] <= nxt[i];
    end
  end
endmodule

// File: rtl/isr_mirror.sv
module isr_mirror
  import isr_pkg::*;
(
  input  logic [CFG_W-1:0] cfg,
  output logic [MIR_N-1:0] mir
);
  for (genvar k = 0; k < MIR_N; k++) begin : g_slot
    localparam int SRC = mir_src(k);
    assign mir[k] = cfg[SRC];
  end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import isr_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 16'h3060,
  parameter int                NUM_MBOX   = 8,
  parameter bit                HOST_MODE  = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [STAT_W-1:0]   wdata,
  output logic [STAT_W-1:0]   rdata,
  input  logic                line_in,
  input  logic [CFG_W-1:0]    cfg_status,
  input  logic [NUM_MBOX-1:0] mbox_wr,
  output logic                irq_out
);
  logic                hit_wr, hit_rd;
  logic [STAT_W-1:0]   clr_mask;
  logic                edge_q, edge_nxt;
  logic [NUM_MBOX-1:0] mb_q, mb_nxt;
  logic [MIR_N-1:0]    mir;
  logic [STAT_W-1:0]   stat_word;

  assign hit_wr   = wr_en && (addr == REG_OFFSET);
  assign hit_rd   = rd_en && (addr == REG_OFFSET);
  assign clr_mask = hit_wr ? wdata : '0;

  if (HOST_MODE) begin : g_host
    isr_edge_flag u_edge (
      .clk      (clk),
      .rst      (rst),
      .line     (line_in),
      .clr      (clr_mask[EDGE_BIT]),
      .flag_q   (edge_q),
      .flag_nxt (edge_nxt)
    );
  end else begin : g_dev
    assign edge_q   = 1'b0;
    assign edge_nxt = 1'b0;
  end

  isr_sticky_bank #(.N(NUM_MBOX)) u_mbox (
    .clk (clk),
    .rst (rst),
    .set (mbox_wr),
    .clr (clr_mask[MBOX_LSB +: NUM_MBOX]),
    .q   (mb_q),
    .nxt (mb_nxt)
  );

  isr_mirror u_mir (
    .cfg (cfg_status),
    .mir (mir)
  );

  always_comb begin
    stat_word                        = '0;
    stat_word[EDGE_BIT]              = edge_q;
    stat_word[MIR_LSB +: MIR_N]      = mir;
    stat_word[MBOX_LSB +: NUM_MBOX]  = mb_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata   <= '0;
      irq_out <= 1'b0;
    end else begin
      rdata   <= hit_rd ? stat_word : '0;
      irq_out <= edge_nxt | (|mb_nxt) | (|mir);
    end
  end
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
  import isr_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 16'h3060,
  parameter int                NUM_MBOX   = 8,
  parameter bit                HOST_MODE  = 1'b1
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic                rd_en,
  input logic [ADDR_W-1:0]   addr,
  input logic [STAT_W-1:0]   rdata,
  input logic                line_in,
  input logic [CFG_W-1:0]    cfg_status,
  input logic [NUM_MBOX-1:0] mbox_wr,
  input logic                irq_out,
  input logic [STAT_W-1:0]   stat
);
  logic wr_hit;
  assign wr_hit = wr_en && (addr == REG_OFFSET);

  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (rst)
    (HOST_MODE && line_in && !$past(line_in)) |=> stat[EDGE_BIT]); // R2

  AST_NO_EDGE_DEV: assert property (@(posedge clk) disable iff (rst)
    !HOST_MODE |-> !stat[EDGE_BIT]); // R4

  AST_MIRROR_MAP: assert property (@(posedge clk) disable iff (rst)
    stat[MIR_LSB +: MIR_N] == {cfg_status[15], cfg_status[14], cfg_status[13],
                               cfg_status[12], cfg_status[11], cfg_status[8]}); // R5

  AST_MBOX_SETS: assert property (@(posedge clk) disable iff (rst)
    (|mbox_wr) |=> ((stat[MBOX_LSB +: NUM_MBOX] & $past(mbox_wr)) == $past(mbox_wr))); // R7

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> ((stat[MBOX_LSB +: NUM_MBOX] & $past(stat[MBOX_LSB +: NUM_MBOX]))
                 == $past(stat[MBOX_LSB +: NUM_MBOX]))); // R8

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rdata[6:0] == '0) && (rdata[15:14] == '0) && (rdata[31:24] == '0)); // R9

  AST_RDATA_IDLE: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rdata == '0)); // R10

  AST_IRQ_COVERS: assert property (@(posedge clk) disable iff (rst)
    ((|stat[MBOX_LSB +: NUM_MBOX]) || stat[EDGE_BIT]) |-> irq_out); // R11
endmodule

bind irq_status_reg irq_status_chk #(
  .ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET), .NUM_MBOX(NUM_MBOX), .HOST_MODE(HOST_MODE)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .rdata(rdata),
  .line_in(line_in), .cfg_status(cfg_status), .mbox_wr(mbox_wr), .irq_out(irq_out),
  .stat(stat_word)
);

// File: tb/irq_status_reg_test.sv
`timescale 1ns/1ps
module irq_status_reg_test;
  localparam logic [15:0] OFS = 16'h3060;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] addr = OFS;
  logic [31:0] wdata = '0;
  logic        line_in = 1'b0;
  logic [15:0] cfg_status = '0;
  logic [7:0]  mbox_wr = '0;
  logic [31:0] rdata, rdata_dev;
  logic        irq_out, irq_dev;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  irq_status_reg uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .line_in(line_in), .cfg_status(cfg_status), .mbox_wr(mbox_wr),
    .irq_out(irq_out)
  );

  irq_status_reg #(.HOST_MODE(1'b0)) uut_dev (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata_dev), .line_in(line_in), .cfg_status(cfg_status), .mbox_wr(mbox_wr),
    .irq_out(irq_dev)
  );

  function automatic logic [5:0] mir_of(input logic [15:0] c);
    return {c[15], c[14], c[13], c[12], c[11], c[8]};
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [15:0] a);
    addr = a; rd_en = 1'b1;
    tick();
    rd_en = 1'b0; addr = OFS;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    tick();
    wr_en = 1'b0; wdata = '0; addr = OFS;
  endtask

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    check("R1 rdata after reset", rdata, 32'h0);
    check("R1 irq after reset", {31'b0, irq_out}, 32'h0);
    rd(OFS);
    check("R1 word after reset", rdata, 32'h0);

    // R2 rising transition sets bit 7
    line_in = 1'b1; tick();
    check("R11 irq tracks edge flag", {31'b0, irq_out}, 32'h1);
    rd(OFS);
    check("R2 edge sets bit7", rdata, 32'h80);
    check("R4 dev mode bit7 zero", rdata_dev, 32'h0);
    check("R4 dev mode no irq", {31'b0, irq_dev}, 32'h0);
    wr(OFS, 32'h80);
    rd(OFS);
    check("R3 w1c clears bit7", rdata, 32'h0);
    line_in = 1'b0; tick(); tick();
    rd(OFS);
    check("R2 steady/falling no set", rdata, 32'h0);
    check("R11 irq low when idle", {31'b0, irq_out}, 32'h0);

    // R3 collision: set bit 7, then clear on a cycle that sees a new edge
    line_in = 1'b1; tick(); line_in = 1'b0; tick();
    line_in = 1'b1; wr(OFS, 32'h80);
    rd(OFS);
    check("R3 edge beats clear", rdata, 32'h80);
    wr(OFS, 32'h0);
    rd(OFS);
    check("R8 write 0 keeps bit7", rdata, 32'h80);
    wr(OFS, 32'h80);
    line_in = 1'b0; tick();

    // R5/R6/R9 mirror sweep over all mapped combinations
    for (int i = 0; i < 64; i++) begin
      logic [15:0] c;
      c = 16'((i * 16'h9e37) ^ 16'h5a5a);
      c[8] = i[0]; c[11] = i[1]; c[12] = i[2];
      c[13] = i[3]; c[14] = i[4]; c[15] = i[5];
      cfg_status = c;
      wr(OFS, 32'hffff_ffff);
      rd(OFS);
      check("R5 mirror map", rdata, {18'b0, mir_of(c), 8'b0});
      check("R6 mirror write ignored", {26'b0, rdata[13:8]}, {26'b0, mir_of(c)});
      check("R11 irq follows mirror", {31'b0, irq_out}, {31'b0, |mir_of(c)});
    end
    cfg_status = 16'h02f7; tick();
    check("R11 unmapped cfg bits no irq", {31'b0, irq_out}, 32'h0);
    cfg_status = '0; tick();

    // R7 mailbox sweep
    for (int n = 0; n < 8; n++) begin
      mbox_wr = 8'(1 << n); tick(); mbox_wr = '0;
      rd(OFS);
      check("R7 mailbox sets flag", rdata, 32'(1) << (16 + n));
      check("R11 irq from mailbox", {31'b0, irq_out}, 32'h1);
      wr(OFS, ~(32'(1) << (16 + n)));
      rd(OFS);
      check("R8 other w1c bits keep flag", rdata, 32'(1) << (16 + n));
      mbox_wr = 8'(1 << n); wr(OFS, 32'(1) << (16 + n)); mbox_wr = '0;
      rd(OFS);
      check("R7 mailbox beats clear", rdata, 32'(1) << (16 + n));
      wr(OFS, 32'(1) << (16 + n));
      rd(OFS);
      check("R7 w1c clears mailbox", rdata, 32'h0);
    end

    // R9 all sources active
    mbox_wr = 8'hff; cfg_status = 16'hffff; line_in = 1'b1; tick();
    mbox_wr = '0;
    rd(OFS);
    check("R9 reserved zero all set", rdata, 32'h00ff_3f80);
    check("R4 dev mode all set", rdata_dev, 32'h00ff_3f00);

    // R10 address decode
    rd(16'h3064);
    check("R10 other address reads 0", rdata, 32'h0);
    wr(16'h3064, 32'hffff_ffff);
    wr(16'h2060, 32'hffff_ffff);
    rd(OFS);
    check("R10 other address write ignored", rdata, 32'h00ff_3f80);
    tick();
    check("R10 rdata 0 without read", rdata, 32'h0);

    // R1 reset clears sticky state
    rst = 1'b1; tick(); rst = 1'b0; cfg_status = '0; line_in = 1'b0;
    rd(OFS);
    check("R1 reset clears flags", rdata, 32'h0);
    tick();
    check("R1 irq low after reset", {31'b0, irq_out}, 32'h0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule